// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects level-sensitive interrupt requests into banks of 32 sources and folds them onto one request line toward a parent processor. Each source input passes through a two-stage synchroniser, and the synchronised level is visible in a per-bank status register. A per-bank mask register decides which sources may reach the output. Software changes the mask only through two write-only ports: one whose 1-bits disable sources and one whose 1-bits enable them. Neither needs a read-modify-write.

Software reads a per-bank pending register that shows sources that are both active and enabled. It then walks those bits itself, from the highest set bit downward. The block has no priority logic and no vector generation. The number of banks is a parameter, meant to be one or two. Banks repeat in the address map at a fixed 0x20 stride. Nothing is latched on edges: a source counts as active only while its device holds it high.

Top module: `lvl_irq_hub`

## Requirements
- R1: While reset is held, and right after it, every mask bit of every bank reads 1, every pending bit reads 0 and `irq_o` is low.
- R2: The status register (bank offset 0x00) returns each source's level, delayed by two clock edges. A change is not yet visible after only one edge.
- R3: A write to bank offset 0x08 sets every mask bit whose write-data bit is 1, which disables that source. Mask bits written with 0 keep their value.
- R4: A write to bank offset 0x0C clears every mask bit whose write-data bit is 1, which enables that source. Mask bits written with 0 keep their value.
- R5: The mask register reads back at bank offset 0x04. Writes to offset 0x04 and to the status offset 0x00 change nothing.
- R6: The pending register (bank offset 0x10) reads status AND NOT mask.
- R7: `irq_o` is the OR of all pending bits of all banks. A mask write affects `irq_o` in the cycle right after the write edge.
- R8: Bank n occupies addresses n*0x20 through n*0x20+0x1F, and each bank's registers act only on that bank's 32 sources (bank 1 source k is `src_i[32+k]`).
- R9: Reads of offsets other than 0x00, 0x04 and 0x10, and reads of bank indices at or above the bank count, return zero. Writes there change no mask.
- R10: A source that drops low clears its status and pending bits two edges later. No earlier assertion is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Level interrupt requests, bank b source k at bit 32*b+k |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
On every cycle, the assertions check three things. The first is the two-edge latency of the synchroniser. The second is that set-mask and clear-mask writes land on exactly the written bits, with the mask held steady when there is no such write. The third is that `irq_o` stays low while every source is masked, along with the reset value of the mask. The address decode can only be shown by the bench's scenarios: the bank stride, the zero reads from holes, and the ignored writes to read-only or unmapped addresses. The same holds for the pending read-back value, and for the way a dropped source level clears the output with no memory of the earlier request.

// File: rtl/lvl_irq_pkg.sv
// Package: shared constants for the banked level interrupt controller.
// Assumes byte addressing with 32-bit registers and a 0x20 bank stride.
package lvl_irq_pkg;
    localparam int BANK_SRCS = 32;
    localparam int OFS_W     = 5;
    localparam logic [OFS_W-1:0] OFS_STATUS = 5'h00;
    localparam logic [OFS_W-1:0] OFS_MASK   = 5'h04;
    localparam logic [OFS_W-1:0] OFS_SETM   = 5'h08;
    localparam logic [OFS_W-1:0] OFS_CLRM   = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_PEND   = 5'h10;
endpackage

// File: rtl/lvl_irq_sync.sv
// Module: two-flop synchroniser for one bank of level sources.
// Assumes sources are quasi-static levels. Output lags input by two edges.
module lvl_irq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       warm_q;

    // Two-stage capture of the raw source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    // Counts edges since reset so the latency check starts once history exists.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assign level_o = stage2_q;

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (level_o == $past(async_i, 2))); // R2
endmodule

// File: rtl/lvl_irq_mask_bank.sv
// Module: mask register and pending logic for one bank.
// Assumes set and clear strobes are never active together (distinct addresses).
module lvl_irq_mask_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] mask_q;

    // Mask update: resets to all-disabled, otherwise bit-selective set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '1;
        else if (set_we) mask_q <= mask_q | wdata;
        else if (clr_we) mask_q <= mask_q & ~wdata;
    end

    // Pending view: active sources that are not masked.
    always_comb begin
        pend_o = level_i & ~mask_q;
    end

    assign mask_o = mask_q;

    AST_MASK_RESET: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1)); // R1
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && $past(rst_n)) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R3
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && $past(rst_n)) |=> ((mask_q & $past(wdata)) == '0)); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we && $past(rst_n)) |=> $stable(mask_q)); // R5
endmodule

// File: rtl/lvl_irq_rdmux.sv
// Module: read-data selection across banks and register offsets.
// Assumes flat vectors with bank b in bits [32*b +: 32]. Holes read zero.
module lvl_irq_rdmux
    import lvl_irq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BSEL_W    = 3
) (
    input  logic [BSEL_W-1:0]              bank_sel,
    input  logic [OFS_W-1:0]               ofs,
    input  logic [NUM_BANKS*BANK_SRCS-1:0] status_all,
    input  logic [NUM_BANKS*BANK_SRCS-1:0] mask_all,
    input  logic [NUM_BANKS*BANK_SRCS-1:0] pend_all,
    output logic [BANK_SRCS-1:0]           rdata
);
    // Pick the addressed bank's register, or zero for anything unmapped.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BSEL_W'(b)) begin
                case (ofs)
                    OFS_STATUS: rdata = status_all[b*BANK_SRCS +: BANK_SRCS];
                    OFS_MASK:   rdata = mask_all[b*BANK_SRCS +: BANK_SRCS];
                    OFS_PEND:   rdata = pend_all[b*BANK_SRCS +: BANK_SRCS];
                    default:    rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/lvl_irq_hub.sv
// Module: top of the banked level interrupt controller.
// Decodes the register bus, repeats synchroniser and mask logic per bank,
// and ORs every pending bit onto one request line.
// Assumes ADDR_W is large enough to address all banks at a 0x20 stride.
module lvl_irq_hub
    import lvl_irq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_BANKS*BANK_SRCS-1:0] src_i,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [BANK_SRCS-1:0]           bus_wdata,
    output logic [BANK_SRCS-1:0]           bus_rdata,
    output logic                           irq_o
);
    localparam int SRC_W  = NUM_BANKS * BANK_SRCS;
    localparam int BSEL_W = ADDR_W - OFS_W;

    logic [BSEL_W-1:0]    bank_sel;
    logic [OFS_W-1:0]     ofs;
    logic [NUM_BANKS-1:0] set_we;
    logic [NUM_BANKS-1:0] clr_we;
    logic [SRC_W-1:0]     status_all;
    logic [SRC_W-1:0]     mask_all;
    logic [SRC_W-1:0]     pend_all;

    assign bank_sel = bus_addr[ADDR_W-1:OFS_W];
    assign ofs      = bus_addr[OFS_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Write strobes for this bank's set-mask and clear-mask ports.
        always_comb begin
            set_we[b] = bus_we && (bank_sel == BSEL_W'(b)) && (ofs == OFS_SETM);
            clr_we[b] = bus_we && (bank_sel == BSEL_W'(b)) && (ofs == OFS_CLRM);
        end

        lvl_irq_sync #(.WIDTH(BANK_SRCS)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (src_i[b*BANK_SRCS +: BANK_SRCS]),
            .level_o (status_all[b*BANK_SRCS +: BANK_SRCS])
        );

        lvl_irq_mask_bank #(.WIDTH(BANK_SRCS)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_we  (set_we[b]),
            .clr_we  (clr_we[b]),
            .wdata   (bus_wdata),
            .level_i (status_all[b*BANK_SRCS +: BANK_SRCS]),
            .mask_o  (mask_all[b*BANK_SRCS +: BANK_SRCS]),
            .pend_o  (pend_all[b*BANK_SRCS +: BANK_SRCS])
        );
    end

    lvl_irq_rdmux #(.NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W)) u_rdmux (
        .bank_sel   (bank_sel),
        .ofs        (ofs),
        .status_all (status_all),
        .mask_all   (mask_all),
        .pend_all   (pend_all),
        .rdata      (bus_rdata)
    );

    // Combined request: any enabled active source in any bank.
    always_comb begin
        irq_o = |pend_all;
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_all) |-> !irq_o); // R7
endmodule

// File: tb/lvl_irq_hub_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module lvl_irq_hub_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 2;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*32-1:0] src = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    lvl_irq_hub #(.NUM_BANKS(NB), .ADDR_W(AW)) u_lvl_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(8'h04, rv); chk("R1 bank0 mask in reset", rv, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h24, rv); chk("R1 bank1 mask", rv, 32'hFFFF_FFFF);
        rd(8'h10, rv); chk("R1 pending", rv, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_status();
        @(negedge clk);
        src = {32'h0000_00F0, 32'hA5A5_0001};
        @(posedge clk); @(negedge clk);
        rd(8'h00, rv); chk("R2 status after one edge", rv, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(8'h00, rv); chk("R2 status bank0", rv, 32'hA5A5_0001);
        rd(8'h20, rv); chk("R8 status bank1", rv, 32'h0000_00F0);
        chk("R7 irq low all masked", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_set_clear();
        wr(8'h0C, 32'h0000_0001);
        chk("R7 irq next cycle after unmask", {31'd0, irq}, 32'd1);
        rd(8'h04, rv); chk("R4 clear bit0", rv, 32'hFFFF_FFFE);
        wr(8'h0C, 32'h8000_0000);
        rd(8'h04, rv); chk("R4 clear keeps others", rv, 32'h7FFF_FFFE);
        rd(8'h10, rv); chk("R6 pending", rv, 32'h8000_0001);
        wr(8'h08, 32'h0000_0001);
        rd(8'h04, rv); chk("R3 set bit0", rv, 32'h7FFF_FFFF);
        rd(8'h10, rv); chk("R6 pending after set", rv, 32'h8000_0000);
        wr(8'h08, 32'h8000_0000);
        rd(8'h10, rv); chk("R3 pending cleared", rv, 32'h0);
        chk("R7 irq low after remask", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_readonly();
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, rv); chk("R5 mask write ignored", rv, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, rv); chk("R5 status write ignored", rv, 32'hA5A5_0001);
        chk("R5 irq stays low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_bank1();
        wr(8'h2C, 32'h0000_0010);
        rd(8'h24, rv); chk("R8 bank1 mask", rv, 32'hFFFF_FFEF);
        rd(8'h30, rv); chk("R8 bank1 pending", rv, 32'h0000_0010);
        rd(8'h04, rv); chk("R8 bank0 untouched", rv, 32'hFFFF_FFFF);
        chk("R7 irq from bank1", {31'd0, irq}, 32'd1);
        wr(8'h28, 32'h0000_0010);
        chk("R7 irq off after bank1 set", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_unmapped();
        rd(8'h14, rv); chk("R9 hole 0x14", rv, 32'h0);
        rd(8'h1C, rv); chk("R9 hole 0x1C", rv, 32'h0);
        rd(8'h40, rv); chk("R9 bank2 status", rv, 32'h0);
        rd(8'h50, rv); chk("R9 bank2 pending", rv, 32'h0);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h04, rv); chk("R9 bank0 mask after bad write", rv, 32'hFFFF_FFFF);
        rd(8'h24, rv); chk("R9 bank1 mask after bad write", rv, 32'hFFFF_FFFF);
        chk("R9 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_level();
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h10, rv); chk("R10 pending active", rv, 32'hA5A5_0001);
        src[31:0] = 32'h0;
        @(posedge clk); @(negedge clk);
        chk("R10 irq held one edge", {31'd0, irq}, 32'd1);
        @(posedge clk); @(negedge clk);
        rd(8'h10, rv); chk("R10 pending dropped", rv, 32'h0);
        chk("R10 irq dropped", {31'd0, irq}, 32'd0);
        src[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(8'h10, rv); chk("R10 pending reasserted", rv, 32'h0000_0008);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_status();
        t_set_clear();
        t_readonly();
        t_bank1();
        t_unmapped();
        t_level();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule